// File: doc/BRIEF.md
# Two-Way Interrupt Mailbox

This block holds two 16-bit interrupt mailboxes between a host agent and a local processor. Each mailbox has one writer side and one recipient side. The host-to-local mailbox is written by the host and consumed by the local processor. The local-to-host mailbox is written by the local processor and consumed by the host. Bus decoding lies outside the block. Each side is reduced to a write strobe with data, a clearing-read strobe, and data outputs.

A shared mode input selects how writes land in both mailboxes. In vector mode (mode = 0, the expected default) a write replaces every bit. In sticky mode (mode = 1) a written 1 sets its bit and a written 0 leaves the bit alone. In both modes a clearing read by the recipient returns the value held before that edge and empties the mailbox. If a write arrives in the same cycle as the read, the written bits stay.

The recipient of the host-to-local mailbox has an interrupt that is high while any bit is set. The host interrupt from the local-to-host mailbox is also gated by an enable input.

Top module: `irq_mailbox_pair`

## Requirements
- R1: While `rst` is high, and on the first edge after it, both views, both read-data outputs and both interrupts are 0.
- R2: With `sticky_mode` = 0, a write makes the mailbox view equal the written data on the next edge, so bits can go to 0 as well as to 1.
- R3: With `sticky_mode` = 1, a write makes the view equal the old view OR the written data. A written 0 has no effect, and a write of all zeros leaves the view unchanged.
- R4: A clearing read without a write empties the mailbox. A clearing read together with a write leaves exactly the written data, in either mode.
- R5: On a clearing read, the read-data output captures the view held before that edge. Without a clearing read, the read-data output holds its value.
- R6: `h2l_irq` is high exactly when any bit of `h2l_view` is set. A vector-mode write of all zeros therefore leaves it low.
- R7: `l2h_irq` is high exactly when any bit of `l2h_view` is set and `l2h_irq_en` was high in the previous cycle.
- R8: The views can be read at any time and have no side effect. Leaving all strobes low keeps every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sticky_mode | input | 1 | 0 = vector write, 1 = set-only write |
| h2l_wr | input | 1 | Host writes the host-to-local mailbox |
| h2l_wdata | input | 16 | Host write data |
| h2l_clr_rd | input | 1 | Local processor clearing read |
| h2l_rdata | output | 16 | Value captured by the last local clearing read |
| h2l_view | output | 16 | Current host-to-local value (writer-side read) |
| h2l_irq | output | 1 | Interrupt to the local processor |
| l2h_wr | input | 1 | Local processor writes the local-to-host mailbox |
| l2h_wdata | input | 16 | Local write data |
| l2h_clr_rd | input | 1 | Host clearing read |
| l2h_rdata | output | 16 | Value captured by the last host clearing read |
| l2h_view | output | 16 | Current local-to-host value (writer-side read) |
| l2h_irq_en | input | 1 | Enable of the host interrupt |
| l2h_irq | output | 1 | Interrupt to the host |

## Verification
The bench walks single bits, all-zero and dense patterns through both modes, and switches modes in the middle of the stream. A design that cleared on a zero write in sticky mode, or one that kept old bits in vector mode, would show a wrong view on the next edge. Clearing reads are placed on the same edge as writes: a design that let the clear win would lose the written bits, and one that captured the new value would return the wrong read data. Zero-data writes and toggling of the enable probe the interrupts. A design that raised the recipient interrupt on any write, or that ignored the enable's one-cycle latency, would be caught.

// File: rtl/irq_mailbox_pkg.sv
package irq_mailbox_pkg;
  localparam int unsigned MBOX_W = 16;
  localparam int unsigned N_LANES = 2;
  typedef enum logic { LANE_H2L = 1'b0, LANE_L2H = 1'b1 } lane_e;
  typedef enum logic { WR_VECTOR = 1'b0, WR_STICKY = 1'b1 } wr_mode_e;
endpackage

// File: rtl/mbox_lane.sv
module mbox_lane #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sticky,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  output logic [W-1:0] nxt,
  output logic [W-1:0] value,
  output logic [W-1:0] rdata
);
  import irq_mailbox_pkg::*;

  logic [W-1:0] base;
  wr_mode_e     mode;

  assign mode = wr_mode_e'(sticky);
  assign base = clr ? '0 : value;

  always_comb begin
    nxt = base;
    if (wr) begin
      if (mode == WR_STICKY) nxt = base | wdata;
      else                   nxt = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      rdata <= '0;
    end else begin
      value <= nxt;
      if (clr) rdata <= value;
    end
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] bits,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en & (|bits);
  end
endmodule

// File: rtl/irq_mailbox_pair.sv
module irq_mailbox_pair #(
  parameter int unsigned W = irq_mailbox_pkg::MBOX_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sticky_mode,
  input  logic         h2l_wr,
  input  logic [W-1:0] h2l_wdata,
  input  logic         h2l_clr_rd,
  output logic [W-1:0] h2l_rdata,
  output logic [W-1:0] h2l_view,
  output logic         h2l_irq,
  input  logic         l2h_wr,
  input  logic [W-1:0] l2h_wdata,
  input  logic         l2h_clr_rd,
  output logic [W-1:0] l2h_rdata,
  output logic [W-1:0] l2h_view,
  input  logic         l2h_irq_en,
  output logic         l2h_irq
);
  import irq_mailbox_pkg::*;
  localparam int unsigned NL = N_LANES;

  logic         wr_a  [NL];
  logic [W-1:0] wd_a  [NL];
  logic         clr_a [NL];
  logic         en_a  [NL];
  logic [W-1:0] nxt_a [NL];
  logic [W-1:0] val_a [NL];
  logic [W-1:0] rd_a  [NL];
  logic         irq_a [NL];

  assign wr_a[LANE_H2L]  = h2l_wr;
  assign wd_a[LANE_H2L]  = h2l_wdata;
  assign clr_a[LANE_H2L] = h2l_clr_rd;
  assign en_a[LANE_H2L]  = 1'b1;
  assign wr_a[LANE_L2H]  = l2h_wr;
  assign wd_a[LANE_L2H]  = l2h_wdata;
  assign clr_a[LANE_L2H] = l2h_clr_rd;
  assign en_a[LANE_L2H]  = l2h_irq_en;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    mbox_lane #(.W(W)) u_lane (
      .clk(clk), .rst(rst), .sticky(sticky_mode),
      .wr(wr_a[g]), .wdata(wd_a[g]), .clr(clr_a[g]),
      .nxt(nxt_a[g]), .value(val_a[g]), .rdata(rd_a[g])
    );
    mbox_irq #(.W(W)) u_irq (
      .clk(clk), .rst(rst), .en(en_a[g]), .bits(nxt_a[g]), .irq(irq_a[g])
    );
  end

  assign h2l_view  = val_a[LANE_H2L];
  assign h2l_rdata = rd_a[LANE_H2L];
  assign h2l_irq   = irq_a[LANE_H2L];
  assign l2h_view  = val_a[LANE_L2H];
  assign l2h_rdata = rd_a[LANE_L2H];
  assign l2h_irq   = irq_a[LANE_L2H];
endmodule

// File: rtl/irq_mailbox_pair_chk.sv
module irq_mailbox_pair_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         sticky_mode,
  input logic         h2l_wr,
  input logic [W-1:0] h2l_wdata,
  input logic         h2l_clr_rd,
  input logic [W-1:0] h2l_rdata,
  input logic [W-1:0] h2l_view,
  input logic         h2l_irq,
  input logic         l2h_wr,
  input logic [W-1:0] l2h_wdata,
  input logic         l2h_clr_rd,
  input logic [W-1:0] l2h_rdata,
  input logic [W-1:0] l2h_view,
  input logic         l2h_irq_en,
  input logic         l2h_irq
);
  p_vector_write_r2: assert property (@(posedge clk) disable iff (rst)
    (h2l_wr && !sticky_mode) |=> (h2l_view == $past(h2l_wdata)));

  p_sticky_write_r3: assert property (@(posedge clk) disable iff (rst)
    (h2l_wr && sticky_mode && !h2l_clr_rd) |=> (h2l_view == ($past(h2l_view) | $past(h2l_wdata))));

  p_clear_read_r4: assert property (@(posedge clk) disable iff (rst)
    (l2h_clr_rd && !l2h_wr) |=> (l2h_view == '0));

  p_clear_capture_r5: assert property (@(posedge clk) disable iff (rst)
    h2l_clr_rd |=> (h2l_rdata == $past(h2l_view)));

  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !l2h_clr_rd |=> $stable(l2h_rdata));

  p_local_irq_r6: assert property (@(posedge clk) disable iff (rst)
    h2l_irq == (|h2l_view));

  p_host_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (!$rose(rst) && !$fell(rst)) |-> (l2h_irq == ((|l2h_view) && $past(l2h_irq_en))));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!h2l_wr && !h2l_clr_rd) |=> $stable(h2l_view));
endmodule

bind irq_mailbox_pair irq_mailbox_pair_chk #(.W(W)) u_chk (.*);

// File: tb/irq_mailbox_pair_test.sv
`timescale 1ns/1ps
module irq_mailbox_pair_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sticky_mode = 1'b0;
  logic h2l_wr = 1'b0, h2l_clr_rd = 1'b0;
  logic l2h_wr = 1'b0, l2h_clr_rd = 1'b0, l2h_irq_en = 1'b0;
  logic [W-1:0] h2l_wdata = '0, l2h_wdata = '0;
  logic [W-1:0] h2l_rdata, h2l_view, l2h_rdata, l2h_view;
  logic h2l_irq, l2h_irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] eh_v = '0, eh_r = '0, el_v = '0, el_r = '0;
  logic         en_prev = 1'b0;

  always #4 clk = ~clk;

  irq_mailbox_pair #(.W(W)) uut (.*);

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] next_val(input logic [W-1:0] v, input logic st,
                                            input logic wr, input logic [W-1:0] d, input logic clr);
    logic [W-1:0] b;
    b = clr ? '0 : v;
    if (!wr) return b;
    return st ? (b | d) : d;
  endfunction

  function automatic string tag_of(input logic st, input logic wr, input logic clr);
    if (clr) return "R4";
    if (!wr) return "R8";
    return st ? "R3" : "R2";
  endfunction

  task automatic cyc(input logic st,
                     input logic hw, input logic [W-1:0] hd, input logic hc,
                     input logic lw, input logic [W-1:0] ld, input logic lc,
                     input logic en);
    sticky_mode = st;
    h2l_wr = hw; h2l_wdata = hd; h2l_clr_rd = hc;
    l2h_wr = lw; l2h_wdata = ld; l2h_clr_rd = lc;
    l2h_irq_en = en;
    if (hc) eh_r = eh_v;
    if (lc) el_r = el_v;
    eh_v = next_val(eh_v, st, hw, hd, hc);
    el_v = next_val(el_v, st, lw, ld, lc);
    @(negedge clk);
    chk({tag_of(st, hw, hc), " h2l view"}, h2l_view, eh_v);
    chk({tag_of(st, lw, lc), " l2h view"}, l2h_view, el_v);
    chk("R5 h2l rdata", h2l_rdata, eh_r);
    chk("R5 l2h rdata", l2h_rdata, el_r);
    chk("R6 h2l irq", {15'd0, h2l_irq}, {15'd0, |eh_v});
    chk("R7 l2h irq", {15'd0, l2h_irq}, {15'd0, (|el_v) & en});
    en_prev = en;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 0);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 h2l view", h2l_view, '0);
    chk("R1 l2h view", l2h_view, '0);
    chk("R1 rdata", h2l_rdata | l2h_rdata, '0);
    chk("R1 irqs", {14'd0, h2l_irq, l2h_irq}, '0);
    rst = 1'b0;
    cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);

    // vector mode: walking ones, zero writes, periodic clears
    for (int i = 0; i <= 16; i++) begin
      logic [W-1:0] p;
      p = (i < 16) ? (16'h1 << i) : 16'h0;
      cyc(1'b0, 1'b1, p, (i % 4) == 3, 1'b1, ~p, (i % 5) == 4, i[0]);
    end
    // R6: zero write in vector mode leaves interrupt low
    cyc(1'b0, 1'b1, '0, 1'b0, 1'b1, '0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1);

    // sticky mode: accumulate, zero writes, clear with concurrent write
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] p;
      p = ((i % 6) == 5) ? 16'h0 : (16'h1 << (i % 16));
      cyc(1'b1, (i % 3) != 2, p, (i % 8) == 7, 1'b1, p ^ 16'h8001, (i % 9) == 8, (i % 4) < 2);
    end

    // mixed sweep with mode switching
    for (int i = 0; i < 128; i++) begin
      logic [W-1:0] p;
      p = W'(i * 16'h2F3B) ^ W'(i << 5);
      cyc(i[4], (i % 3) != 0, p, (i % 5) == 0, (i % 4) != 1, ~p, (i % 7) == 3, i[1]);
    end
    // R8: idle cycles hold everything
    repeat (4) cyc(1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule